// File: doc/BRIEF.md
# Serial Flash Write Guard and Status Control

This block is the gatekeeper for write traffic in a small serial flash controller. A command decoder upstream turns each received opcode into a one-cycle strobe and presents the target address alongside it. The guard owns the status register: the busy flag, the write-enable latch and two protect bits that reserve a top-aligned slice of the array. For every program, erase or status-write strobe it answers with a one-cycle grant or reject pulse. After a grant on an array operation it holds busy for a parameterised number of clock cycles, standing in for the self-timed internal write.

Protection comes from three independent sources. The latch must be set before any write. The protect bits cover a top-of-array fraction. The active-low write-protect pin locks the status register only and has no effect on array writes. The status byte is always visible for readout, including while busy. The serial shifter and the storage array live elsewhere.

Top module: `flash_guard`

## Requirements
- R1: After reset the status byte reads 0x00, and grant_o, reject_o and busy_o are low.
- R2: When not busy, wren_i sets the write-enable latch (status bit 1) and wrdi_i clears it, visible one cycle after the strobe.
- R3: A program, sector erase, block erase, chip erase or status write issued while the latch is clear gives a reject_o pulse in the cycle after the strobe and no grant.
- R4: With the full-size organisation (LARGE_ORG=1, 17 address bits), protect setting 00 protects nothing, 01 protects addresses from 0x18000 up, 10 protects from 0x10000 up and 11 protects all. The setting sits in status bits 3 (upper) and 2 (lower).
- R5: With the half-size organisation (LARGE_ORG=0), any nonzero protect setting protects the whole array.
- R6: A program covers the 256-byte page holding addr_i, a sector erase covers 4 KB, a block erase covers 32 KB and a chip erase covers everything. The request is rejected if any byte of that span is protected.
- R7: While wp_ni is low a status write is rejected and the protect bits stay unchanged. Array writes ignore wp_ni.
- R8: A granted program holds busy_o and status bit 0 high for PROG_CYCLES cycles. A granted erase holds them for ERASE_CYCLES cycles.
- R9: A granted status write loads sr_bp_i into the protect bits, finishes in one cycle and never raises busy.
- R10: The write-enable latch clears when a request is rejected, when a status write is granted and when a busy period ends. It stays set during busy.
- R11: While busy, every strobe is ignored: no grant or reject, and no change to the latch or the protect bits.
- R12: grant_o and reject_o are one-cycle pulses that are never high together. At most one command strobe is high per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| prog_i | input | 1 | Page program strobe |
| sect_erase_i | input | 1 | Sector erase strobe |
| blk_erase_i | input | 1 | Block erase strobe |
| chip_erase_i | input | 1 | Chip erase strobe |
| wrsr_i | input | 1 | Status write strobe |
| addr_i | input | ADDR_W | Target byte address of the request |
| sr_bp_i | input | 2 | Protect bits carried by a status write |
| wp_ni | input | 1 | Write-protect pin, active low |
| grant_o | output | 1 | Request accepted (pulse) |
| reject_o | output | 1 | Request refused (pulse) |
| busy_o | output | 1 | Self-timed write in progress |
| status_o | output | 8 | Status byte: bit0 busy, bit1 latch, bits3:2 protect, rest zero |

## Verification
The main function is driven from a vector table. Each vector pairs a protect setting with an operation kind and an address chosen just below or just at a protected boundary, so that an off-by-one boundary, a wrong span mask or a swapped quarter/half decode each flip a grant into a reject. Vectors with the latch clear separate the latch check from the range check. Vectors with the pin low on array operations confirm that the pin does not leak into array protection. Directed cases cover the pin lock on status writes, strobes during busy, and a second instance with the half-size organisation receiving the same stimulus. On that second instance the same low address is refused where the full-size part grants it.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_SECT, OP_BLK, OP_CHIP, OP_WRSR
  } wr_op_e;

  localparam int PAGE_BITS = 8;
  localparam int SECT_BITS = 12;
  localparam int BLK_BITS  = 15;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_BP   = 2;
endpackage

// File: rtl/fg_region.sv
module fg_region
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter bit LARGE_ORG = 1'b1
) (
  input  logic [1:0]        bp_i,
  input  wr_op_e            op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] PAGE_M = ADDR_W'((1 << PAGE_BITS) - 1);
  localparam logic [ADDR_W-1:0] SECT_M = ADDR_W'((1 << SECT_BITS) - 1);
  localparam logic [ADDR_W-1:0] BLK_M  = ADDR_W'((1 << BLK_BITS) - 1);

  logic [ADDR_W-1:0] span_m, span_end, lo;
  logic              array_op;

  always_comb begin
    unique case (op_i)
      OP_PROG: span_m = PAGE_M;
      OP_SECT: span_m = SECT_M;
      OP_BLK:  span_m = BLK_M;
      default: span_m = '1;
    endcase
  end

  assign span_end = addr_i | span_m;
  assign array_op = (op_i == OP_PROG) || (op_i == OP_SECT) ||
                    (op_i == OP_BLK)  || (op_i == OP_CHIP);

  // lowest protected address; region always runs to the top
  generate
    if (LARGE_ORG) begin : g_large
      always_comb begin
        unique case (bp_i)
          2'b01:   lo = {2'b11, {(ADDR_W-2){1'b0}}};
          2'b10:   lo = {1'b1,  {(ADDR_W-1){1'b0}}};
          default: lo = '0;
        endcase
      end
    end else begin : g_small
      assign lo = '0;
    end
  endgenerate

  assign hit_o = array_op && (bp_i != 2'b00) && (span_end >= lo);
endmodule

// File: rtl/fg_timer.sv
module fg_timer #(
  parameter int PROG_CYCLES  = 100_000,
  parameter int ERASE_CYCLES = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic busy_o,
  output logic done_o
);
  localparam int MAX_C = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= long_i ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  // R8
  busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  // R11
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && busy_o));
endmodule

// File: rtl/fg_status.sv
module fg_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       bp_we_i,
  input  logic [1:0] bp_d_i,
  output logic       wel_o,
  output logic [1:0] bp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wel_o <= 1'b0;
    else if (clr_wel_i) wel_o <= 1'b0;
    else if (set_wel_i) wel_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bp_o <= 2'b00;
    else if (bp_we_i) bp_o <= bp_d_i;
  end

  // R10
  wel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wel_i |=> !wel_o);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter bit LARGE_ORG    = 1'b1,
  parameter int PROG_CYCLES  = 100_000,
  parameter int ERASE_CYCLES = 2_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              prog_i,
  input  logic              sect_erase_i,
  input  logic              blk_erase_i,
  input  logic              chip_erase_i,
  input  logic              wrsr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        sr_bp_i,
  input  logic              wp_ni,
  output logic              grant_o,
  output logic              reject_o,
  output logic              busy_o,
  output logic [7:0]        status_o
);
  wr_op_e     op;
  logic       idle, req, deny, accept, refuse, hit;
  logic       wel, done, t_start, t_long, sr_we;
  logic [1:0] bp;
  logic [6:0] strb;

  assign strb = {wren_i, wrdi_i, prog_i, sect_erase_i, blk_erase_i, chip_erase_i, wrsr_i};

  always_comb begin
    if (prog_i)            op = OP_PROG;
    else if (sect_erase_i) op = OP_SECT;
    else if (blk_erase_i)  op = OP_BLK;
    else if (chip_erase_i) op = OP_CHIP;
    else if (wrsr_i)       op = OP_WRSR;
    else                   op = OP_NONE;
  end

  assign idle    = !busy_o;
  assign req     = idle && (op != OP_NONE);
  assign deny    = !wel || hit || ((op == OP_WRSR) && !wp_ni);
  assign accept  = req && !deny;
  assign refuse  = req && deny;
  assign sr_we   = accept && (op == OP_WRSR);
  assign t_start = accept && (op != OP_WRSR);
  assign t_long  = (op != OP_PROG);

  fg_region #(.ADDR_W(ADDR_W), .LARGE_ORG(LARGE_ORG)) u_region (
    .bp_i(bp), .op_i(op), .addr_i(addr_i), .hit_o(hit)
  );

  fg_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(t_start), .long_i(t_long),
    .busy_o(busy_o), .done_o(done)
  );

  fg_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_wel_i(idle && wren_i),
    .clr_wel_i((idle && wrdi_i) || refuse || sr_we || done),
    .bp_we_i(sr_we), .bp_d_i(sr_bp_i),
    .wel_o(wel), .bp_o(bp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o  <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      grant_o  <= accept;
      reject_o <= refuse;
    end
  end

  assign status_o = {4'b0000, bp, wel, busy_o};

  // R12
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb));

  // R12
  grant_reject_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && reject_o));

  // R3
  no_wel_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(strb) && (op != OP_NONE) && !busy_o && !status_o[ST_WEL]) |=> reject_o);

  // R7
  wp_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrsr_i && !wp_ni && $onehot0(strb)) |=> (!grant_o && $stable(status_o[3:2])));

  // R6
  chip_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_erase_i && $onehot0(strb) && !busy_o && (status_o[3:2] != 2'b00)) |=> reject_o);

  // R11
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (strb != '0)) |=> (!grant_o && !reject_o && $stable(status_o[3:2])));

  // R9
  sr_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && $past(wrsr_i)) |-> !busy_o);
endmodule

// File: tb/tb_flash_guard.sv
module tb_flash_guard;
  localparam int PROG_C  = 8;
  localparam int ERASE_C = 20;
  localparam int OP_WREN = 0, OP_WRDI = 1, OP_PROG = 2, OP_SECT = 3,
                 OP_BLK = 4, OP_CHIP = 5, OP_WRSR = 6;

  typedef struct packed {
    logic [1:0]  bp;
    logic        wel;
    logic        wp;
    logic [2:0]  op;
    logic [16:0] addr;
    logic        exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b1, 3'd2, 17'h1FF00, 1'b1},  // R6 unprotected top page
    '{2'd0, 1'b0, 1'b1, 3'd2, 17'h00000, 1'b0},  // R3 latch clear
    '{2'd1, 1'b1, 1'b1, 3'd2, 17'h18000, 1'b0},  // R4 quarter boundary
    '{2'd1, 1'b1, 1'b1, 3'd2, 17'h17F00, 1'b1},  // R4 just below quarter
    '{2'd1, 1'b1, 1'b1, 3'd3, 17'h17FFF, 1'b1},  // R6 sector below
    '{2'd1, 1'b1, 1'b1, 3'd4, 17'h18000, 1'b0},  // R6 block inside
    '{2'd1, 1'b1, 1'b1, 3'd5, 17'h00000, 1'b0},  // R6 chip overlaps
    '{2'd2, 1'b1, 1'b1, 3'd4, 17'h0F000, 1'b1},  // R4 block under half
    '{2'd2, 1'b1, 1'b1, 3'd3, 17'h10000, 1'b0},  // R4 half boundary
    '{2'd2, 1'b1, 1'b0, 3'd2, 17'h00100, 1'b1},  // R7 pin ignored for array
    '{2'd3, 1'b1, 1'b1, 3'd2, 17'h00000, 1'b0},  // R4 all protected
    '{2'd0, 1'b1, 1'b0, 3'd5, 17'h00000, 1'b1}   // R7 chip erase, pin low
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wren = 0, wrdi = 0, prog = 0, sect = 0, blk = 0, chip = 0, wrsr = 0, wp_n = 1;
  logic [16:0] addr = '0;
  logic [1:0]  bpd = '0;
  logic        grant, reject, busy, grant_s, reject_s, busy_s;
  logic [7:0]  status, status_s;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  flash_guard #(.ADDR_W(17), .LARGE_ORG(1'b1), .PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdi_i(wrdi), .prog_i(prog),
    .sect_erase_i(sect), .blk_erase_i(blk), .chip_erase_i(chip), .wrsr_i(wrsr),
    .addr_i(addr), .sr_bp_i(bpd), .wp_ni(wp_n),
    .grant_o(grant), .reject_o(reject), .busy_o(busy), .status_o(status));

  flash_guard #(.ADDR_W(16), .LARGE_ORG(1'b0), .PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C)) dut_s (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdi_i(wrdi), .prog_i(prog),
    .sect_erase_i(sect), .blk_erase_i(blk), .chip_erase_i(chip), .wrsr_i(wrsr),
    .addr_i(addr[15:0]), .sr_bp_i(bpd), .wp_ni(wp_n),
    .grant_o(grant_s), .reject_o(reject_s), .busy_o(busy_s), .status_o(status_s));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the sampling posedge
  task automatic issue(input int op, input logic [16:0] a, input logic [1:0] d);
    addr = a; bpd = d;
    wren = (op == OP_WREN); wrdi = (op == OP_WRDI); prog = (op == OP_PROG);
    sect = (op == OP_SECT); blk = (op == OP_BLK); chip = (op == OP_CHIP);
    wrsr = (op == OP_WRSR);
    @(negedge clk);
    {wren, wrdi, prog, sect, blk, chip, wrsr} = '0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while ((busy || busy_s) && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic set_bp(input logic [1:0] b);
    wp_n = 1'b1;
    issue(OP_WREN, '0, '0);
    issue(OP_WRSR, '0, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [1:0] cur_bp;
    repeat (3) @(negedge clk);
    // R1
    chk(status == 8'h00 && !grant && !reject && !busy, "R1", "reset state",
        {grant, reject, busy, status}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2
    issue(OP_WREN, '0, '0);
    chk(status == 8'h02, "R2", "wren sets latch", status, 8'h02);
    issue(OP_WRDI, '0, '0);
    chk(status == 8'h00, "R2", "wrdi clears latch", status, 8'h00);

    // R7: pin low locks status write
    issue(OP_WREN, '0, '0);
    wp_n = 1'b0;
    issue(OP_WRSR, '0, 2'b11);
    chk(reject && !grant, "R7", "status write with pin low", {grant, reject}, 2'b01);
    chk(status == 8'h00, "R7", "protect bits kept, latch cleared", status, 8'h00);
    wp_n = 1'b1;

    // R9
    issue(OP_WREN, '0, '0);
    issue(OP_WRSR, '0, 2'b11);
    chk(grant && !busy && status == 8'h0C, "R9", "status write grant",
        {grant, status}, {1'b1, 8'h0C});
    @(negedge clk);
    chk(!grant && !busy, "R12", "grant is one pulse", {grant, busy}, 0);

    // R5: same low-address program on both organisations, protect 01
    set_bp(2'b01);
    chk(status_s == 8'h04, "R5", "small part protect bits", status_s, 8'h04);
    issue(OP_WREN, '0, '0);
    issue(OP_PROG, 17'h00000, '0);
    chk(reject_s && !grant_s, "R5", "small part nonzero protect covers all",
        {grant_s, reject_s}, 2'b01);
    chk(grant && !reject, "R4", "large part low address free with 01",
        {grant, reject}, 2'b10);
    wait_busy(n);

    // R11 / R10: strobes during busy
    set_bp(2'b00);
    issue(OP_WREN, '0, '0);
    issue(OP_PROG, 17'h00200, '0);
    chk(grant && busy, "R8", "program starts busy", {grant, busy}, 2'b11);
    issue(OP_WRDI, '0, '0);
    chk(status[1] == 1'b1 && !grant && !reject, "R11", "wrdi ignored while busy",
        status, 8'h03);
    issue(OP_WRSR, '0, 2'b11);
    chk(!grant && !reject && status[3:2] == 2'b00, "R11", "status write ignored while busy",
        {grant, reject, status}, 8'h03);
    wait_busy(n);
    chk(status == 8'h00, "R10", "latch cleared at end of busy", status, 8'h00);

    // vector table
    cur_bp = 2'b00;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].bp != cur_bp) begin
        set_bp(VECS[i].bp);
        cur_bp = VECS[i].bp;
      end
      if (VECS[i].wel) issue(OP_WREN, '0, '0);
      wp_n = VECS[i].wp;
      issue(int'(VECS[i].op), VECS[i].addr, '0);
      chk(grant == VECS[i].exp && reject == !VECS[i].exp,
          (VECS[i].op == 3'd2 && !VECS[i].wel) ? "R3" : "R6", $sformatf("vector %0d", i),
          {grant, reject}, {VECS[i].exp, !VECS[i].exp});
      if (VECS[i].exp) begin
        wait_busy(n);
        chk(n == ((VECS[i].op == 3'd2) ? PROG_C : ERASE_C), "R8",
            $sformatf("busy length vector %0d", i), n,
            (VECS[i].op == 3'd2) ? PROG_C : ERASE_C);
      end else begin
        wait_busy(n);
      end
      chk(status[1] == 1'b0, "R10", $sformatf("latch clear after vector %0d", i),
          status, {cur_bp, 2'b00});
      wp_n = 1'b1;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule